// File: doc/BRIEF.md
# Digital Potentiometer Wiper Controller

This block is the digital control section of a 32-position solid-state potentiometer. Three slow, asynchronous pins drive it: an active-low select, a direction level and a step strobe. All three are brought into a fast system clock domain. The block keeps a saturating wiper position and drives a one-hot tap-select bus that closes one switch of the resistor array. When the position changes, the old and the new tap are both enabled for a fixed number of clocks before the old one opens, so the wiper never floats.

A neighbouring store controller uses the block in two ways. It loads the recalled position through a synchronous load port, and that load wins over any step in the same cycle. It also receives one-cycle pulses when the pins select or deselect the device. A deselect is reported as a store request when the strobe is high at that moment, and as a plain release otherwise. Until the first load arrives, the tap bus stays all-zero and strobes are not acted on.

Top module: `dpw_wiper_ctrl`

## Requirements
- R1: After reset, `wiper_pos` is 0, `tap_sel` is all-zero and all three event outputs are low.
- R2: A cycle with `load_en` high sets `wiper_pos` to `load_pos` at the next clock edge, even if a step falls due in that same cycle. Once the block has been loaded, `tap_sel` settles to the single bit whose index equals `wiper_pos`.
- R3: While selected (`sel_n_pin` low), a high-to-low transition of `step_pin` moves the position by one: up when `dir_pin` is 1, down when it is 0. A low-to-high transition has no effect.
- R4: The position saturates. A step up from 31 leaves it at 31, and a step down from 0 leaves it at 0.
- R5: While `sel_n_pin` is high, activity on `step_pin` and `dir_pin` leaves `wiper_pos` and `tap_sel` unchanged.
- R6: Before the first load, strobes do not move the position and `tap_sel` stays all-zero.
- R7: After the position changes from A to B, `tap_sel` has exactly bits A and B set for `OVERLAP_CYC` clock cycles, then only bit B. It never has more than two bits set.
- R8: `dir_pin` may change between strobes while the device stays selected, and each strobe uses the level present at its own edge.
- R9: `sel_evt` pulses high for one cycle when the synchronised select falls.
- R10: When the synchronised select rises, `desel_store` pulses for one cycle if the synchronised strobe is high, and `desel_nostore` pulses otherwise. At most one of the three event outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n_pin | input | 1 | Asynchronous active-low select pin |
| dir_pin | input | 1 | Asynchronous direction pin, 1 = up |
| step_pin | input | 1 | Asynchronous step strobe, acts on its falling edge |
| load_en | input | 1 | Synchronous position load strobe from the store controller |
| load_pos | input | 5 | Position value to load |
| tap_sel | output | 32 | One-hot tap switch enables, two bits set during overlap |
| wiper_pos | output | 5 | Current wiper position |
| sel_evt | output | 1 | One-cycle pulse when the device is selected |
| desel_store | output | 1 | One-cycle pulse when deselected with the strobe high |
| desel_nostore | output | 1 | One-cycle pulse when deselected with the strobe low |

## Verification
A wrong position register shows on `wiper_pos` one clock after the faulty update. It also shows on `tap_sel` one clock later, because the tap stage follows the position with one register. A stuck or mis-loaded overlap counter shows within `OVERLAP_CYC` plus one cycles, as a tap bus with the wrong number of bits set or with the old tap held too long. A bad edge detector or synchroniser shows about three clocks after a pin change, as a missing, doubled or wrongly directed step, or as a wrong event pulse.

// File: rtl/dpw_pkg.sv
package dpw_pkg;

    localparam int TAP_COUNT = 32;
    localparam int POS_W     = $clog2(TAP_COUNT);
    localparam int POS_MAX   = TAP_COUNT - 1;

    typedef logic [POS_W-1:0]     pos_t;
    typedef logic [TAP_COUNT-1:0] tap_t;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    // one request per clock into the position register
    typedef struct packed {
        logic step;
        dir_e dir;
        logic load;
        pos_t load_val;
    } pos_cmd_t;

    typedef struct packed {
        logic sel;
        logic desel_store;
        logic desel_nostore;
    } bus_evt_t;

    function automatic pos_t sat_step(input pos_t p, input dir_e d);
        pos_t r;
        r = p;
        if (d == DIR_UP) begin
            if (p != pos_t'(POS_MAX)) r = p + 1'b1;
        end else begin
            if (p != '0) r = p - 1'b1;
        end
        return r;
    endfunction

    function automatic tap_t tap_onehot(input pos_t p);
        tap_t t;
        t    = '0;
        t[p] = 1'b1;
        return t;
    endfunction

endpackage

// File: rtl/dpw_sync.sv
module dpw_sync #(
    parameter int                 WIDTH   = 3,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/dpw_pos_reg.sv
module dpw_pos_reg
    import dpw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pos_cmd_t cmd,
    output pos_t     pos,
    output logic     loaded
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos    <= '0;
            loaded <= 1'b0;
        end else if (cmd.load) begin
            pos    <= cmd.load_val;
            loaded <= 1'b1;
        end else if (cmd.step && loaded) begin
            pos    <= sat_step(pos, cmd.dir);
        end
    end

endmodule

// File: rtl/dpw_tap_drive.sv
module dpw_tap_drive
    import dpw_pkg::*;
#(
    parameter int OVERLAP_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  pos_t pos,
    input  logic valid,
    output tap_t tap
);

    localparam int CNT_W = (OVERLAP_CYC < 1) ? 1 : $clog2(OVERLAP_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(OVERLAP_CYC);

    pos_t             cur_q;
    pos_t             old_q;
    logic             armed_q;
    logic [CNT_W-1:0] ovl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '0;
            old_q   <= '0;
            armed_q <= 1'b0;
            ovl_q   <= '0;
        end else if (valid && !armed_q) begin
            cur_q   <= pos;
            armed_q <= 1'b1;
            ovl_q   <= '0;
        end else if (armed_q && (pos != cur_q)) begin
            old_q   <= cur_q;
            cur_q   <= pos;
            ovl_q   <= CNT_LOAD;
        end else if (ovl_q != '0) begin
            ovl_q   <= ovl_q - 1'b1;
        end
    end

    always_comb begin
        tap = '0;
        if (armed_q) begin
            tap = tap_onehot(cur_q);
            if (ovl_q != '0) tap = tap | tap_onehot(old_q);
        end
    end

endmodule

// File: rtl/dpw_wiper_ctrl.sv
module dpw_wiper_ctrl
    import dpw_pkg::*;
#(
    parameter int OVERLAP_CYC = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_n_pin,
    input  logic             dir_pin,
    input  logic             step_pin,
    input  logic             load_en,
    input  logic [POS_W-1:0] load_pos,
    output logic [TAP_COUNT-1:0] tap_sel,
    output logic [POS_W-1:0] wiper_pos,
    output logic             sel_evt,
    output logic             desel_store,
    output logic             desel_nostore
);

    // synchronised pins: {select_n, step, dir}; idle levels on reset
    logic [2:0] pins_s;
    logic       sel_n_s;
    logic       step_s;
    logic       dir_s;
    logic       sel_n_d;
    logic       step_d;
    logic       loaded;
    pos_cmd_t   cmd;
    bus_evt_t   evt;
    pos_t       pos;

    dpw_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b110)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({sel_n_pin, step_pin, dir_pin}),
        .q  (pins_s)
    );

    assign sel_n_s = pins_s[2];
    assign step_s  = pins_s[1];
    assign dir_s   = pins_s[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_n_d <= 1'b1;
            step_d  <= 1'b1;
        end else begin
            sel_n_d <= sel_n_s;
            step_d  <= step_s;
        end
    end

    always_comb begin
        cmd.step     = step_d & ~step_s & ~sel_n_s;
        cmd.dir      = dir_e'(dir_s);
        cmd.load     = load_en;
        cmd.load_val = load_pos;

        evt.sel           = sel_n_d & ~sel_n_s;
        evt.desel_store   = ~sel_n_d & sel_n_s & step_s;
        evt.desel_nostore = ~sel_n_d & sel_n_s & ~step_s;
    end

    dpw_pos_reg u_pos (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .pos   (pos),
        .loaded(loaded)
    );

    dpw_tap_drive #(
        .OVERLAP_CYC(OVERLAP_CYC)
    ) u_tap (
        .clk  (clk),
        .rst  (rst),
        .pos  (pos),
        .valid(loaded),
        .tap  (tap_sel)
    );

    assign wiper_pos     = pos;
    assign sel_evt       = evt.sel;
    assign desel_store   = evt.desel_store;
    assign desel_nostore = evt.desel_nostore;

endmodule

// File: rtl/dpw_wiper_chk.sv
module dpw_wiper_chk
    import dpw_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 sel_n_s,
    input logic                 load_en,
    input logic [POS_W-1:0]     wiper_pos,
    input logic [TAP_COUNT-1:0] tap_sel,
    input logic                 sel_evt,
    input logic                 desel_store,
    input logic                 desel_nostore
);

    logic [POS_W-1:0] pos_q;
    logic             load_q;
    logic [POS_W:0]   pos_diff;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            load_q <= 1'b0;
        end else begin
            pos_q  <= wiper_pos;
            load_q <= load_en;
        end
    end

    assign pos_diff = {1'b0, wiper_pos} - {1'b0, pos_q};

    // R7: never more than old and new tap together
    p_tap_bound_r7: assert property (@(posedge clk) disable iff (rst)
        $countones(tap_sel) <= 2);

    // R2: a settled position is always among the enabled taps
    p_tap_tracks_r2: assert property (@(posedge clk) disable iff (rst)
        (tap_sel != '0) && $stable(wiper_pos) |-> tap_sel[wiper_pos]);

    // R4: without a load the position moves by at most one and never wraps
    p_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        !load_q |-> (pos_diff == '0) || (pos_diff == 1) || (pos_diff == '1));

    // R5: deselected and no load means the position holds
    p_desel_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        sel_n_s && !load_en |=> $stable(wiper_pos));

    // R10: event pulses are mutually exclusive
    p_evt_excl_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_evt, desel_store, desel_nostore}));

endmodule

bind dpw_wiper_ctrl dpw_wiper_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .sel_n_s      (sel_n_s),
    .load_en      (load_en),
    .wiper_pos    (wiper_pos),
    .tap_sel      (tap_sel),
    .sel_evt      (sel_evt),
    .desel_store  (desel_store),
    .desel_nostore(desel_nostore)
);

// File: tb/test_dpw_wiper_ctrl.sv
`timescale 1ns/1ps
module test_dpw_wiper_ctrl;

    localparam int  OVL     = 4;
    localparam time CLK_PER = 20ns;

    typedef struct packed {
        logic       sel_n;
        logic       dir;
        logic [4:0] exp;
    } vec_t;

    // walked after loading 29 while selected
    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b1, 5'd30},   // R3 up
        '{1'b0, 1'b1, 5'd31},   // R3 up to top
        '{1'b0, 1'b1, 5'd31},   // R4 saturate high
        '{1'b0, 1'b0, 5'd30},   // R8 direction change while selected
        '{1'b1, 1'b1, 5'd30},   // R5 ignored when deselected
        '{1'b1, 1'b0, 5'd30},   // R5 ignored when deselected
        '{1'b0, 1'b0, 5'd29},   // R3 down
        '{1'b0, 1'b1, 5'd30}    // R8 up again
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n_pin = 1'b1;
    logic        dir_pin = 1'b0;
    logic        step_pin = 1'b1;
    logic        load_en = 1'b0;
    logic [4:0]  load_pos = '0;
    logic [31:0] tap_sel;
    logic [4:0]  wiper_pos;
    logic        sel_evt, desel_store, desel_nostore;

    int n_tests = 0;
    int n_fail  = 0;
    int c_sel = 0, c_store = 0, c_nostore = 0;

    always #(CLK_PER/2) clk = ~clk;

    dpw_wiper_ctrl #(.OVERLAP_CYC(OVL)) i_dpw_wiper_ctrl (
        .clk(clk), .rst(rst),
        .sel_n_pin(sel_n_pin), .dir_pin(dir_pin), .step_pin(step_pin),
        .load_en(load_en), .load_pos(load_pos),
        .tap_sel(tap_sel), .wiper_pos(wiper_pos),
        .sel_evt(sel_evt), .desel_store(desel_store), .desel_nostore(desel_nostore)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (sel_evt)       c_sel++;
            if (desel_store)   c_store++;
            if (desel_nostore) c_nostore++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic strobe_fall();
        step_pin = 1'b0;
        tick(12);
    endtask

    task automatic strobe_rise();
        step_pin = 1'b1;
        tick(12);
    endtask

    task automatic do_load(input logic [4:0] p);
        load_pos = p;
        load_en  = 1'b1;
        tick(1);
        load_en  = 1'b0;
        tick(12);
    endtask

    initial begin
        #(CLK_PER * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int s0, st0, ns0, ovl_cnt;
        tick(4);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        check(wiper_pos == 5'd0, "R1", "position after reset", 32'(wiper_pos), 32'd0);
        check(tap_sel == '0, "R1", "tap bus after reset", tap_sel, 32'd0);
        check({sel_evt, desel_store, desel_nostore} == 3'b000, "R1", "events after reset",
              32'({sel_evt, desel_store, desel_nostore}), 32'd0);

        // R6 strobes before any load
        sel_n_pin = 1'b0;
        dir_pin   = 1'b1;
        tick(8);
        check(c_sel == 1, "R9", "select pulse count", 32'(c_sel), 32'd1);
        strobe_fall(); strobe_rise();
        strobe_fall(); strobe_rise();
        check(wiper_pos == 5'd0, "R6", "position before load", 32'(wiper_pos), 32'd0);
        check(tap_sel == '0, "R6", "tap bus before load", tap_sel, 32'd0);
        sel_n_pin = 1'b1;
        tick(8);
        check(c_store == 1 && c_nostore == 0, "R10", "store pulse on deselect, strobe high",
              32'({c_store[15:0], c_nostore[15:0]}), 32'h0001_0000);

        // R2 load
        sel_n_pin = 1'b0;
        tick(8);
        do_load(5'd29);
        check(wiper_pos == 5'd29, "R2", "loaded position", 32'(wiper_pos), 32'd29);
        check(tap_sel == (32'd1 << 29), "R2", "tap after load", tap_sel, 32'd1 << 29);

        // vector walk
        foreach (VECS[i]) begin
            sel_n_pin = VECS[i].sel_n;
            tick(8);
            dir_pin = VECS[i].dir;
            tick(4);
            strobe_fall();
            check(wiper_pos == VECS[i].exp, "R3/R4/R5/R8", $sformatf("vector %0d position", i),
                  32'(wiper_pos), 32'(VECS[i].exp));
            check(tap_sel == (32'd1 << VECS[i].exp), "R2/R5/R7", $sformatf("vector %0d tap", i),
                  tap_sel, 32'd1 << VECS[i].exp);
            strobe_rise();
            check(wiper_pos == VECS[i].exp, "R3", $sformatf("vector %0d rising strobe", i),
                  32'(wiper_pos), 32'(VECS[i].exp));
        end

        // R4 saturation at the bottom
        do_load(5'd1);
        dir_pin = 1'b0;
        tick(4);
        strobe_fall(); strobe_rise();
        check(wiper_pos == 5'd0, "R4", "step down to zero", 32'(wiper_pos), 32'd0);
        strobe_fall(); strobe_rise();
        check(wiper_pos == 5'd0, "R4", "step below zero", 32'(wiper_pos), 32'd0);
        check(tap_sel == 32'd1, "R4", "tap at zero", tap_sel, 32'd1);

        // R2 load wins over a step in the same cycle
        do_load(5'd20);
        dir_pin = 1'b1;
        tick(4);
        step_pin = 1'b0;
        tick(2);
        load_pos = 5'd10;
        load_en  = 1'b1;
        tick(1);
        load_en  = 1'b0;
        tick(12);
        check(wiper_pos == 5'd10, "R2", "load priority over step", 32'(wiper_pos), 32'd10);
        strobe_rise();
        check(wiper_pos == 5'd10, "R3", "rising strobe no step", 32'(wiper_pos), 32'd10);

        // R7 make-before-break overlap length
        ovl_cnt  = 0;
        step_pin = 1'b0;
        for (int k = 0; k < 20; k++) begin
            tick(1);
            if (tap_sel == ((32'd1 << 10) | (32'd1 << 11))) ovl_cnt++;
        end
        check(ovl_cnt == OVL, "R7", "overlap cycles", 32'(ovl_cnt), 32'(OVL));
        check(tap_sel == (32'd1 << 11), "R7", "tap after overlap", tap_sel, 32'd1 << 11);
        check(wiper_pos == 5'd11, "R3", "step after overlap", 32'(wiper_pos), 32'd11);

        // R10 / R9 deselect with strobe low, then reselect
        s0 = c_sel; st0 = c_store; ns0 = c_nostore;
        sel_n_pin = 1'b1;
        tick(8);
        check(c_nostore == ns0 + 1 && c_store == st0, "R10", "release pulse on deselect, strobe low",
              32'({c_store[15:0], c_nostore[15:0]}), 32'({st0[15:0], ns0[15:0] + 16'd1}));
        step_pin = 1'b1;
        tick(8);
        sel_n_pin = 1'b0;
        tick(8);
        check(c_sel == s0 + 1, "R9", "select pulse on reselect", 32'(c_sel), 32'(s0 + 1));
        check(wiper_pos == 5'd11, "R5", "position held across deselect", 32'(wiper_pos), 32'd11);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule